// File: doc/BRIEF.md
# Two-Segment Frame Transmitter

This block streams one outgoing packet into a byte-wide output FIFO. The packet is built from two regions of a 64-bit word memory. A start pulse supplies a header region (word address and byte length) and a payload region (word address and byte length). The block sends a lead-in, then the header bytes, then a CRC-32 check over the header alone. It then sends the payload bytes and a second CRC-32 over the payload alone, which closes the packet. A receiver can use the header check to accept a packet that writes its payload straight into memory at an address given by the sender.

Two lead-ins are supported. The normal lead-in is the usual Ethernet preamble and start-of-frame byte. The alternate-route lead-in is a one-byte logical link address followed by a start byte that is deliberately invalid, so that downstream logic steers the packet to a separate serial link. A small receive-side checker is included. It runs CRC-32 over an incoming header and its four check bytes, and reports whether the check matched.

Top module: `two_seg_frame_tx`

## Requirements
- R1: After reset, busy, done, tx_valid, mem_rd, rx_hdr_good and rx_hdr_bad are all low.
- R2: With route_alt low, a packet opens with PRE_LEN (default 7) bytes of 0x55 followed by 0xD5.
- R3: With route_alt high, a packet opens with the link_addr byte followed by 0x00 in place of the preamble and start byte.
- R4: Segment bytes are sent in increasing address order, starting at byte 0 of the given word. Within a memory word, bits [7:0] go out first and bits [63:56] go out last.
- R5: Right after the last header byte come four check bytes. They hold the CRC-32 of the header bytes only, sent least significant byte first. The CRC uses reflected polynomial 0xEDB88320 (normal form 0x04C11DB7), an initial value of all ones and a final inversion.
- R6: The payload bytes follow the header check. Four further check bytes close the packet. They hold the CRC-32 of the payload bytes only, computed the same way as in R5.
- R7: A segment of length zero sends no data bytes. Its check is the CRC of an empty string, four 0x00 bytes.
- R8: A byte is transferred on a clock edge where tx_valid is high and tx_full is low. While tx_full is high, tx_valid and tx_data hold steady. No byte is lost or repeated.
- R9: done is a one-cycle pulse in the cycle after the final check byte is transferred, and busy is low in that same cycle.
- R10: start is ignored while busy is high. The packet in flight is unchanged, and no second packet follows it.
- R11: The cycle after a byte arrives with rx_valid and rx_end both high, exactly one of rx_hdr_good or rx_hdr_bad pulses. rx_hdr_good pulses when the check bytes match the bytes before them.
- R12: Each memory read is a one-cycle mem_rd pulse. Read data is taken one cycle later, and no byte is sent in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a packet (sampled while idle) |
| hdr_addr | input | ADDR_W | Header word address |
| hdr_len | input | LEN_W | Header length in bytes |
| pay_addr | input | ADDR_W | Payload word address |
| pay_len | input | LEN_W | Payload length in bytes |
| route_alt | input | 1 | Use the link-address lead-in |
| link_addr | input | 8 | Logical link address byte |
| busy | output | 1 | Packet in progress |
| done | output | 1 | Packet complete pulse |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after mem_rd |
| tx_valid | output | 1 | Output byte present |
| tx_data | output | 8 | Output byte |
| tx_full | input | 1 | Output FIFO full |
| rx_valid | input | 1 | Receive byte strobe |
| rx_data | input | 8 | Receive byte |
| rx_end | input | 1 | Marks the last check byte |
| rx_hdr_good | output | 1 | Header check matched |
| rx_hdr_bad | output | 1 | Header check failed |

## Verification
The bench targets the known check value of the nine-digit ASCII string. A wrong bit order, seed or inversion would change those four bytes. It also targets empty header and payload segments, where a design that fetches anyway or reuses a stale CRC sends extra bytes or a non-zero check. Random FIFO backpressure catches designs that advance, drop or duplicate a byte while full. Payload runs that cross word boundaries expose a missed refetch or a skipped byte. Two further cases are covered. A start pulsed mid-packet would corrupt a design that latches it. A corrupted byte fed to the receive checker must produce a bad pulse rather than a good one.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_PRE, S_LINK, S_SOF, S_FETCH, S_WAIT, S_BYTE, S_FCS
   } ftx_state_e;

   localparam logic [7:0]  PRE_BYTE    = 8'h55;
   localparam logic [7:0]  SOF_BYTE    = 8'hD5;
   localparam logic [7:0]  BAD_SOF     = 8'h00;
   localparam logic [31:0] CRC_POLY_R  = 32'hEDB88320;
   localparam logic [31:0] CRC_INIT    = 32'hFFFFFFFF;
   localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

   // one byte of reflected CRC-32, lsb of data first
   function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c;
      for (int i = 0; i < 8; i++)
         r = (r[0] ^ d[i]) ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
      return r;
   endfunction
endpackage

// File: rtl/ftx_crc32.sv
module ftx_crc32
   import ftx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear,
   input  logic        en,
   input  logic [7:0]  data,
   output logic [31:0] crc
);
   logic [31:0] base;
   assign base = clear ? CRC_INIT : crc;

   always_ff @(posedge clk) begin
      if (!rst_n)      crc <= CRC_INIT;
      else if (en)     crc <= crc_byte(base, data);
      else if (clear)  crc <= CRC_INIT;
   end
endmodule

// File: rtl/ftx_rx_hdr_check.sv
module ftx_rx_hdr_check
   import ftx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_valid,
   input  logic [7:0] rx_data,
   input  logic       rx_end,
   output logic       good,
   output logic       bad
);
   logic        end_q;
   logic [31:0] crc;

   ftx_crc32 u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (end_q),
      .en    (rx_valid),
      .data  (rx_data),
      .crc   (crc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) end_q <= 1'b0;
      else        end_q <= rx_valid & rx_end;
   end

   assign good = end_q & (crc == CRC_RESIDUE);
   assign bad  = end_q & (crc != CRC_RESIDUE);

   AST_RX_VERDICT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
      (good || bad) |-> $past(rx_valid && rx_end)) else $error("rx verdict without end byte"); // R11
endmodule

// File: rtl/two_seg_frame_tx.sv
module two_seg_frame_tx
   import ftx_pkg::*;
#(
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned LEN_W   = 12,
   parameter int unsigned PRE_LEN = 7,
   parameter bit          BYTE_LE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] hdr_addr,
   input  logic [LEN_W-1:0]  hdr_len,
   input  logic [ADDR_W-1:0] pay_addr,
   input  logic [LEN_W-1:0]  pay_len,
   input  logic              route_alt,
   input  logic [7:0]        link_addr,
   output logic              busy,
   output logic              done,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   input  logic              tx_full,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   input  logic              rx_end,
   output logic              rx_hdr_good,
   output logic              rx_hdr_bad
);
   localparam int unsigned BPW   = DATA_W / 8;
   localparam int unsigned IDX_W = $clog2(BPW);
   localparam int unsigned PRE_W = $clog2(PRE_LEN + 1);

   generate
      if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0)
         $error("DATA_W must be a power of two of at least 16");
      if (PRE_LEN < 1 || LEN_W < PRE_W || LEN_W < 3)
         $error("PRE_LEN or LEN_W out of range");
   endgenerate

   ftx_state_e        state;
   logic              seg;
   logic [LEN_W-1:0]  cnt;
   logic              alt_q;
   logic [7:0]        link_q;
   logic [ADDR_W-1:0] hbase, pbase;
   logic [LEN_W-1:0]  hlen, plen;
   logic [DATA_W-1:0] wbuf;
   logic [31:0]       crc, crc_inv;
   logic [7:0]        wbyte, fcs_b;
   logic [ADDR_W-1:0] cur_base;
   logic [LEN_W-1:0]  cur_len;
   logic              accept, crc_clr, crc_en;

   assign cur_base = seg ? pbase : hbase;
   assign cur_len  = seg ? plen  : hlen;
   assign accept   = tx_valid & ~tx_full;
   assign busy     = (state != S_IDLE);
   assign mem_rd   = (state == S_FETCH);
   assign mem_addr = cur_base + ADDR_W'(cnt >> IDX_W);

   // byte lane order inside a memory word
   generate
      if (BYTE_LE) begin : g_lane_le
         assign wbyte = wbuf[{cnt[IDX_W-1:0], 3'b000} +: 8];
      end else begin : g_lane_be
         assign wbyte = wbuf[{~cnt[IDX_W-1:0], 3'b000} +: 8];
      end
   endgenerate

   assign crc_inv = ~crc;
   assign fcs_b   = crc_inv[{cnt[1:0], 3'b000} +: 8];
   assign crc_en  = accept & (state == S_BYTE);
   assign crc_clr = (state == S_IDLE) |
                    (accept & (state == S_FCS) & (cnt[1:0] == 2'd3) & ~seg);

   ftx_crc32 u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (crc_clr),
      .en    (crc_en),
      .data  (wbyte),
      .crc   (crc)
   );

   always_comb begin
      tx_valid = 1'b1;
      tx_data  = 8'h00;
      case (state)
         S_PRE:   tx_data = PRE_BYTE;
         S_LINK:  tx_data = link_q;
         S_SOF:   tx_data = alt_q ? BAD_SOF : SOF_BYTE;
         S_BYTE:  tx_data = wbyte;
         S_FCS:   tx_data = fcs_b;
         default: tx_valid = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         seg    <= 1'b0;
         cnt    <= '0;
         alt_q  <= 1'b0;
         link_q <= '0;
         hbase  <= '0;
         pbase  <= '0;
         hlen   <= '0;
         plen   <= '0;
         wbuf   <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            S_IDLE: if (start) begin
               hbase  <= hdr_addr;
               pbase  <= pay_addr;
               hlen   <= hdr_len;
               plen   <= pay_len;
               alt_q  <= route_alt;
               link_q <= link_addr;
               seg    <= 1'b0;
               cnt    <= '0;
               state  <= route_alt ? S_LINK : S_PRE;
            end
            S_PRE: if (accept) begin
               if (cnt == LEN_W'(PRE_LEN - 1)) begin
                  cnt   <= '0;
                  state <= S_SOF;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            S_LINK: if (accept) state <= S_SOF;
            S_SOF: if (accept) begin
               cnt   <= '0;
               state <= (hlen == '0) ? S_FCS : S_FETCH;
            end
            S_FETCH: state <= S_WAIT;
            S_WAIT: begin
               wbuf  <= mem_rdata;
               state <= S_BYTE;
            end
            S_BYTE: if (accept) begin
               if (cnt == cur_len - 1'b1) begin
                  cnt   <= '0;
                  state <= S_FCS;
               end else begin
                  cnt <= cnt + 1'b1;
                  if (&cnt[IDX_W-1:0]) state <= S_FETCH;
               end
            end
            S_FCS: if (accept) begin
               if (cnt[1:0] == 2'd3) begin
                  cnt <= '0;
                  if (!seg) begin
                     seg   <= 1'b1;
                     state <= (plen == '0) ? S_FCS : S_FETCH;
                  end else begin
                     done  <= 1'b1;
                     state <= S_IDLE;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   ftx_rx_hdr_check u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .rx_data  (rx_data),
      .rx_end   (rx_end),
      .good     (rx_hdr_good),
      .bad      (rx_hdr_bad)
   );

   AST_HOLD_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_full) |=> (tx_valid && $stable(tx_data))) else $error("byte moved under full"); // R8
   AST_DONE_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(tx_valid && !tx_full)) else $error("done without final transfer"); // R9
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle"); // R9
   AST_READ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> (!mem_rd && !tx_valid)) else $error("read not followed by capture cycle"); // R12
   AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start)) else $error("busy rose without start"); // R10
endmodule

// File: tb/two_seg_frame_tx_tb.sv
module two_seg_frame_tx_tb;
   localparam int CLK_PERIOD = 10;
   localparam int PRE_LEN    = 7;
   localparam int WD_CYCLES  = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] hdr_addr = '0, pay_addr = '0;
   logic [11:0] hdr_len = '0, pay_len = '0;
   logic        route_alt = 1'b0;
   logic [7:0]  link_addr = '0;
   logic        busy, done, mem_rd, tx_valid, rx_hdr_good, rx_hdr_bad;
   logic [15:0] mem_addr;
   logic [63:0] mem_rdata = '0;
   logic [7:0]  tx_data;
   logic        tx_full = 1'b0;
   logic        rx_valid = 1'b0, rx_end = 1'b0;
   logic [7:0]  rx_data = '0;

   int checks = 0, errors = 0, done_cnt = 0;
   bit bp_en = 1'b0;
   bit hold_pend = 1'b0;
   logic [7:0] hold_data = '0;
   logic [63:0] mem [0:63];
   logic [7:0] got[$];
   logic [7:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   two_seg_frame_tx u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .hdr_addr(hdr_addr), .hdr_len(hdr_len),
      .pay_addr(pay_addr), .pay_len(pay_len), .route_alt(route_alt), .link_addr(link_addr),
      .busy(busy), .done(done), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_full(tx_full),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end),
      .rx_hdr_good(rx_hdr_good), .rx_hdr_bad(rx_hdr_bad)
   );

   always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];

   task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, expv);
      end
   endtask

   // backpressure driver and byte collector, away from the active edge
   always @(negedge clk) begin
      tx_full = bp_en ? 1'($urandom % 2) : 1'b0;
      if (rst_n) begin
         if (hold_pend)
            chk(tx_valid && tx_data == hold_data, "R8", "hold under full", int'(tx_data), int'(hold_data));
         hold_pend = tx_valid && tx_full;
         hold_data = tx_data;
         if (tx_valid && !tx_full) got.push_back(tx_data);
         if (done) done_cnt++;
      end
   end

   function automatic logic [31:0] ref_crc(input logic [7:0] b[$]);
      logic [31:0] c = 32'hFFFFFFFF;
      foreach (b[k]) begin
         c = c ^ {24'h0, b[k]};
         for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
      return ~c;
   endfunction

   function automatic logic [7:0] mem_byte(input int base, input int i);
      logic [63:0] w = mem[(base + i / 8) % 64];
      return w[(i % 8) * 8 +: 8];
   endfunction

   function automatic void add_seg(input int base, input int len);
      logic [7:0] s[$];
      logic [31:0] c;
      for (int i = 0; i < len; i++) s.push_back(mem_byte(base, i));
      c = ref_crc(s);
      foreach (s[k]) exp_q.push_back(s[k]);
      for (int k = 0; k < 4; k++) exp_q.push_back(c[k*8 +: 8]);
   endfunction

   function automatic void build_exp(input int hw, input int hl, input int pw, input int pl,
                                     input bit alt, input logic [7:0] la);
      exp_q.delete();
      if (alt) begin
         exp_q.push_back(la);
         exp_q.push_back(8'h00);
      end else begin
         for (int i = 0; i < PRE_LEN; i++) exp_q.push_back(8'h55);
         exp_q.push_back(8'hD5);
      end
      add_seg(hw, hl);
      add_seg(pw, pl);
   endfunction

   task automatic compare(input int hl, input int pl, input bit alt);
      int pre = alt ? 2 : PRE_LEN + 1;
      string r;
      chk(got.size() == exp_q.size(), "R8", "packet length", got.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got.size(); i++) begin
         if (i < pre)                   r = alt ? "R3" : "R2";
         else if (i < pre + hl)         r = "R4";
         else if (i < pre + hl + 4)     r = (hl == 0) ? "R7" : "R5";
         else if (i < pre + hl + 4 + pl) r = "R6";
         else                           r = (pl == 0) ? "R7" : "R6";
         chk(got[i] == exp_q[i], r, $sformatf("byte %0d", i), int'(got[i]), int'(exp_q[i]));
      end
   endtask

   task automatic launch(input int hw, input int hl, input int pw, input int pl,
                         input bit alt, input logic [7:0] la);
      got.delete();
      build_exp(hw, hl, pw, pl, alt, la);
      @(negedge clk);
      hdr_addr = 16'(hw); hdr_len = 12'(hl); pay_addr = 16'(pw); pay_len = 12'(pl);
      route_alt = alt; link_addr = la; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic finish_frame(input int hl, input int pl, input bit alt);
      while (!done) @(negedge clk);
      chk(!busy, "R9", "busy low with done", int'(busy), 0);
      @(negedge clk);
      chk(!done, "R9", "done single cycle", int'(done), 0);
      compare(hl, pl, alt);
   endtask

   task automatic run_frame(input int hw, input int hl, input int pw, input int pl,
                            input bit alt, input logic [7:0] la);
      launch(hw, hl, pw, pl, alt, la);
      finish_frame(hl, pl, alt);
   endtask

   task automatic rx_feed(input logic [7:0] b[$], input bit expect_good);
      foreach (b[k]) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_data = b[k]; rx_end = (k == b.size() - 1);
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_end = 1'b0;
      chk(rx_hdr_good == expect_good && rx_hdr_bad == !expect_good, "R11", "rx verdict",
          {rx_hdr_good, rx_hdr_bad}, {expect_good, !expect_good});
      @(negedge clk);
      chk(!rx_hdr_good && !rx_hdr_bad, "R11", "rx verdict pulse", {rx_hdr_good, rx_hdr_bad}, 0);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks + 1, errors);
      $finish;
   end

   initial begin
      int seed_v;
      int d0;
      logic [7:0] hb[$];
      logic [31:0] c;
      seed_v = int'($urandom(32'd20240611));
      for (int w = 0; w < 64; w++) mem[w] = {$urandom, $urandom};
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy && !done && !tx_valid && !mem_rd, "R1", "reset outputs", {busy, done, tx_valid, mem_rd}, 0);
      chk(!rx_hdr_good && !rx_hdr_bad, "R1", "reset rx outputs", {rx_hdr_good, rx_hdr_bad}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5 known value: header "123456789"
      mem[0] = 64'h3837363534333231;
      mem[1][7:0] = 8'h39;
      run_frame(0, 9, 20, 16, 1'b0, 8'h00);
      chk(got.size() > PRE_LEN + 13, "R5", "length for known check", got.size(), PRE_LEN + 14);
      if (got.size() > PRE_LEN + 13) begin
         chk(got[PRE_LEN + 1] == 8'h31, "R4", "first header byte", int'(got[PRE_LEN + 1]), 8'h31);
         chk({got[PRE_LEN + 13], got[PRE_LEN + 12], got[PRE_LEN + 11], got[PRE_LEN + 10]} == 32'hCBF43926,
             "R5", "known header check",
             int'({got[PRE_LEN + 13], got[PRE_LEN + 12], got[PRE_LEN + 11], got[PRE_LEN + 10]}), 32'hCBF43926);
      end

      // R3 + R7: alternate route, empty payload
      run_frame(3, 5, 24, 0, 1'b1, 8'hA7);
      chk(got.size() > 1 && got[0] == 8'hA7 && got[1] == 8'h00, "R3", "link lead-in",
          got.size() > 1 ? int'({got[0], got[1]}) : 0, 16'hA700);

      // R7 + R8: empty header, payload under backpressure
      bp_en = 1'b1;
      run_frame(5, 0, 30, 13, 1'b0, 8'h00);

      // R10: start pulsed mid-packet is ignored
      d0 = done_cnt;
      launch(2, 20, 22, 40, 1'b0, 8'h00);
      repeat (15) @(negedge clk);
      hdr_addr = 16'd7; hdr_len = 12'd3; pay_len = 12'd2; route_alt = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      finish_frame(20, 40, 1'b0);
      repeat (40) @(negedge clk);
      chk(done_cnt == d0 + 1 && !busy && got.size() == exp_q.size(), "R10", "no second packet",
          done_cnt - d0, 1);

      // R12 under random frames with mixed backpressure
      for (int n = 0; n < 24; n++) begin
         int hw = $urandom % 9;
         int hl = $urandom % 61;
         int pw = 20 + $urandom % 11;
         int pl = $urandom % 201;
         bit alt = ($urandom % 4) == 0;
         logic [7:0] la = 8'($urandom);
         bp_en = 1'($urandom % 2);
         run_frame(hw, hl, pw, pl, alt, la);
      end
      bp_en = 1'b0;

      // R11: receive header check
      hb.delete();
      for (int i = 0; i < 11; i++) hb.push_back(mem_byte(4, i));
      c = ref_crc(hb);
      for (int k = 0; k < 4; k++) hb.push_back(c[k*8 +: 8]);
      rx_feed(hb, 1'b1);
      hb[3] = hb[3] ^ 8'h10;
      rx_feed(hb, 1'b0);
      hb.delete();
      for (int k = 0; k < 4; k++) hb.push_back(8'h00);
      rx_feed(hb, 1'b1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule